// File: doc/BRIEF.md
# Precision-Aware Floating-Point Register File with NaN Boxing

This block holds the floating-point architectural registers of a core: 32 entries of 64 bits. Every write carries a precision tag. A half or single value written into a 64-bit entry is stored with all bits above the value set to one, which makes the stored pattern a quiet NaN at double precision.

Every read also carries a precision tag and a raw flag. A narrow read checks the stored box. When the box is intact, the read returns the narrow value. When it is not, the read returns the canonical NaN of the requested precision. A raw read, or a read as wide as the register, returns the entry unchanged. This is the path stores use.

A small move unit sits beside the array. It copies bit patterns between the float registers and an external integer register port in both directions, at single or double width. It reports an illegal-operation flag for moves that the configured widths cannot support.

Top module: `fp_boxreg_file`

## Requirements
- R1: A write with precision code 2'b00 (half) stores {48 ones, data[15:0]}. A write with code 2'b01 (single) stores {32 ones, data[31:0]}. Codes 2'b10 (double) and 2'b11 store all 64 data bits unchanged.
- R2: A read with raw=0 and precision half (single) whose stored bits 63..16 (63..32) are all ones returns the low 16 (32) bits, zero-extended to 64 bits.
- R3: A read with raw=0 and a narrow precision whose upper bits are not all ones returns the canonical NaN, zero-extended: 0x7E00 for half and 0x7FC00000 for single.
- R4: A read with raw=1, or with precision code 2'b10 or 2'b11, returns the full 64-bit entry unchanged.
- R5: Reset clears every entry to zero. A raw read after reset gives 0, and a single-precision unboxed read gives 0x7FC00000.
- R6: When a register is written in the same cycle as it is read, every read port sees the newly boxed write data in that cycle. The array takes the value at the rising clock edge.
- R7: A float-to-integer move (mv_to_float=0) with mv_prec=2'b01 returns bits 31..0 of the raw register, sign-extended to the integer width, with no box check.
- R8: An integer-to-float move (mv_to_float=1) with mv_prec=2'b01 writes {32 ones, mv_xsrc[31:0]} to mv_freg.
- R9: Moves with mv_prec=2'b10 copy all 64 bits in either direction, without boxing or unboxing, when the integer and float widths are both at least 64.
- R10: A move with mv_prec of 2'b00 or 2'b11, or a double move when the integer or float width is below 64, raises mv_illegal in the same cycle. It writes nothing, and mv_xres stays zero. mv_xres is also zero whenever no legal float-to-integer move is requested.
- R11: When a legal integer-to-float move and wr_en occur in the same cycle, the move owns the write port and the wr_en write is dropped.
- R12: The two read ports work independently, each with its own address, precision and raw flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable for the general write port |
| wr_addr | input | 5 | Write register index |
| wr_prec | input | 2 | Write precision code |
| wr_data | input | 64 | Write value, low bits significant |
| rd0_addr | input | 5 | Read port 0 index |
| rd0_prec | input | 2 | Read port 0 precision code |
| rd0_raw | input | 1 | Read port 0 bypasses the box check |
| rd0_data | output | 64 | Read port 0 result |
| rd1_addr | input | 5 | Read port 1 index |
| rd1_prec | input | 2 | Read port 1 precision code |
| rd1_raw | input | 1 | Read port 1 bypasses the box check |
| rd1_data | output | 64 | Read port 1 result |
| mv_valid | input | 1 | Move request |
| mv_to_float | input | 1 | 1: integer to float, 0: float to integer |
| mv_prec | input | 2 | Move width code (2'b01 single, 2'b10 double) |
| mv_freg | input | 5 | Float register used by the move |
| mv_xsrc | input | 64 | Integer source value |
| mv_xres | output | 64 | Integer result of a float-to-integer move |
| mv_illegal | output | 1 | Move not supported in this configuration |

## Verification
The hardest case to reach is a narrow, unboxed read of an entry whose box is broken, in the same cycle that the entry is rewritten. A broken box only appears after a double write, a double move, or a half read of a single-boxed value. On top of that, the read address must collide with the write address. The random stimulus draws addresses from a small pool, so writes and reads collide often. It writes data whose upper bits are all ones, partly ones or random, and it mixes every precision on both ports. Directed cases first cover reset, each canonical NaN, move priority, and an illegal double move in a second instance built with a 32-bit integer width.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam int FMAX = 64;

  typedef enum logic [1:0] {
    PREC_H = 2'b00,
    PREC_S = 2'b01,
    PREC_D = 2'b10,
    PREC_X = 2'b11
  } prec_e;

  // Width in bits selected by a precision code, clipped to the register width.
  function automatic int prec_bits(input logic [1:0] p, input int flen);
    int n;
    case (p)
      2'b00:   n = 16;
      2'b01:   n = 32;
      default: n = 64;
    endcase
    if (n > flen) n = flen;
    return n;
  endfunction

  function automatic int exp_bits(input int n);
    int e;
    if (n <= 16)      e = 5;
    else if (n <= 32) e = 8;
    else              e = 11;
    return e;
  endfunction

  // Positive quiet NaN: exponent all ones plus the top significand bit.
  function automatic logic [FMAX-1:0] canon_nan(input int n);
    logic [FMAX-1:0] v;
    int e;
    v = '0;
    e = exp_bits(n);
    for (int i = 0; i < FMAX; i++)
      if (i >= n - 2 - e && i <= n - 2) v[i] = 1'b1;
    return v;
  endfunction

  // Fill every bit at and above position n with ones.
  function automatic logic [FMAX-1:0] box(input logic [FMAX-1:0] d, input int n);
    logic [FMAX-1:0] v;
    for (int i = 0; i < FMAX; i++) v[i] = (i < n) ? d[i] : 1'b1;
    return v;
  endfunction

  // True when bits n .. flen-1 are all ones.
  function automatic logic box_intact(input logic [FMAX-1:0] v, input int n, input int flen);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < FMAX; i++)
      if (i >= n && i < flen && !v[i]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [FMAX-1:0] keep_low(input logic [FMAX-1:0] v, input int n);
    logic [FMAX-1:0] r;
    for (int i = 0; i < FMAX; i++) r[i] = (i < n) ? v[i] : 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/fpr_boxer.sv
module fpr_boxer
  import fpr_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [1:0]      prec,
  input  logic [FLEN-1:0] din,
  output logic [FLEN-1:0] dout
);
  logic [FMAX-1:0] wide_in;
  logic [FMAX-1:0] wide_out;

  always_comb begin
    wide_in = '0;
    wide_in[FLEN-1:0] = din;
    wide_out = box(wide_in, prec_bits(prec, FLEN));
  end

  assign dout = wide_out[FLEN-1:0];
endmodule

// File: rtl/fpr_unboxer.sv
module fpr_unboxer
  import fpr_pkg::*;
#(
  parameter int FLEN = 64
) (
  input  logic [FLEN-1:0] src,
  input  logic [1:0]      prec,
  input  logic            raw,
  output logic [FLEN-1:0] dout,
  output logic            box_ok
);
  logic [FMAX-1:0] wide_src;
  logic [FMAX-1:0] wide_res;
  int              width;

  always_comb begin
    wide_src = '0;
    wide_src[FLEN-1:0] = src;
    width  = prec_bits(prec, FLEN);
    box_ok = box_intact(wide_src, width, FLEN);
    if (raw || width == FLEN)
      wide_res = wide_src;
    else if (box_ok)
      wide_res = keep_low(wide_src, width);
    else
      wide_res = canon_nan(width);
  end

  assign dout = wide_res[FLEN-1:0];
endmodule

// File: rtl/fpr_array.sv
module fpr_array #(
  parameter int NREG = 32,
  parameter int FLEN = 64,
  parameter int NRD  = 3,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [FLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr [NRD],
  output logic [FLEN-1:0] rdata [NRD],
  output logic [NRD-1:0]  fwd_hit
);
  logic [FLEN-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign fwd_hit[g] = we && (waddr == raddr[g]);
    assign rdata[g]   = fwd_hit[g] ? wdata : mem[raddr[g]];
  end
endmodule

// File: rtl/fpr_move.sv
module fpr_move #(
  parameter int XLEN = 64,
  parameter int FLEN = 64
) (
  input  logic            mv_valid,
  input  logic            mv_to_float,
  input  logic [1:0]      mv_prec,
  input  logic [XLEN-1:0] mv_xsrc,
  input  logic [FLEN-1:0] freg_val,
  output logic            illegal,
  output logic            wr_req,
  output logic [1:0]      wr_prec,
  output logic [FLEN-1:0] wr_data,
  output logic [XLEN-1:0] xres
);
  localparam bit DBL_OK = (XLEN >= 64) && (FLEN >= 64);

  logic        legal;
  logic [63:0] x64;
  logic [63:0] f64;
  logic [63:0] wdat64;

  always_comb begin
    x64 = '0;
    x64[XLEN-1:0] = mv_xsrc;
    f64 = '0;
    f64[FLEN-1:0] = freg_val;
  end

  always_comb begin
    case (mv_prec)
      2'b01:   legal = 1'b1;
      2'b10:   legal = DBL_OK;
      default: legal = 1'b0;
    endcase
  end

  assign illegal = mv_valid && !legal;
  assign wr_req  = mv_valid && legal && mv_to_float;
  assign wr_prec = mv_prec;

  always_comb begin
    if (mv_prec == 2'b01) wdat64 = {32'h0, x64[31:0]};
    else                  wdat64 = x64;
  end
  assign wr_data = wdat64[FLEN-1:0];

  always_comb begin
    if (mv_valid && legal && !mv_to_float) begin
      if (mv_prec == 2'b01) xres = XLEN'($signed(f64[31:0]));
      else                  xres = f64[XLEN-1:0];
    end else begin
      xres = '0;
    end
  end
endmodule

// File: rtl/fp_boxreg_file.sv
module fp_boxreg_file
  import fpr_pkg::*;
#(
  parameter int NREG = 32,
  parameter int FLEN = 64,
  parameter int XLEN = 64,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [1:0]      wr_prec,
  input  logic [FLEN-1:0] wr_data,
  input  logic [AW-1:0]   rd0_addr,
  input  logic [1:0]      rd0_prec,
  input  logic            rd0_raw,
  output logic [FLEN-1:0] rd0_data,
  input  logic [AW-1:0]   rd1_addr,
  input  logic [1:0]      rd1_prec,
  input  logic            rd1_raw,
  output logic [FLEN-1:0] rd1_data,
  input  logic            mv_valid,
  input  logic            mv_to_float,
  input  logic [1:0]      mv_prec,
  input  logic [AW-1:0]   mv_freg,
  input  logic [XLEN-1:0] mv_xsrc,
  output logic [XLEN-1:0] mv_xres,
  output logic            mv_illegal
);
  localparam int NRD = 3;

  // Named internal events, observed by the bound checker.
  logic            mv_wr;
  logic [1:0]      mv_wprec;
  logic [FLEN-1:0] mv_wdata;
  logic            wr_fire;
  logic [AW-1:0]   wr_addr_eff;
  logic [1:0]      wr_prec_eff;
  logic [FLEN-1:0] wr_data_eff;
  logic [FLEN-1:0] wr_boxed;
  logic [AW-1:0]   raddr [NRD];
  logic [FLEN-1:0] rsrc  [NRD];
  logic [NRD-1:0]  fwd_hit;
  logic [1:0]      rd_box_ok;
  logic [FLEN-1:0] rd0_src;

  // Write arbitration: a legal move into a float register wins.
  assign wr_fire     = mv_wr || wr_en;
  assign wr_addr_eff = mv_wr ? mv_freg  : wr_addr;
  assign wr_prec_eff = mv_wr ? mv_wprec : wr_prec;
  assign wr_data_eff = mv_wr ? mv_wdata : wr_data;

  fpr_boxer #(.FLEN(FLEN)) u_boxer (
    .prec (wr_prec_eff),
    .din  (wr_data_eff),
    .dout (wr_boxed)
  );

  assign raddr[0] = rd0_addr;
  assign raddr[1] = rd1_addr;
  assign raddr[2] = mv_freg;

  fpr_array #(.NREG(NREG), .FLEN(FLEN), .NRD(NRD)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_fire),
    .waddr   (wr_addr_eff),
    .wdata   (wr_boxed),
    .raddr   (raddr),
    .rdata   (rsrc),
    .fwd_hit (fwd_hit)
  );

  assign rd0_src = rsrc[0];

  fpr_unboxer #(.FLEN(FLEN)) u_unbox0 (
    .src    (rsrc[0]),
    .prec   (rd0_prec),
    .raw    (rd0_raw),
    .dout   (rd0_data),
    .box_ok (rd_box_ok[0])
  );

  fpr_unboxer #(.FLEN(FLEN)) u_unbox1 (
    .src    (rsrc[1]),
    .prec   (rd1_prec),
    .raw    (rd1_raw),
    .dout   (rd1_data),
    .box_ok (rd_box_ok[1])
  );

  fpr_move #(.XLEN(XLEN), .FLEN(FLEN)) u_move (
    .mv_valid    (mv_valid),
    .mv_to_float (mv_to_float),
    .mv_prec     (mv_prec),
    .mv_xsrc     (mv_xsrc),
    .freg_val    (rsrc[2]),
    .illegal     (mv_illegal),
    .wr_req      (mv_wr),
    .wr_prec     (mv_wprec),
    .wr_data     (mv_wdata),
    .xres        (mv_xres)
  );
endmodule

// File: rtl/fpr_checker.sv
module fpr_checker #(
  parameter int FLEN = 64,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_fire,
  input logic            mv_wr,
  input logic            mv_illegal,
  input logic [AW-1:0]   mv_freg,
  input logic [AW-1:0]   wr_addr_eff,
  input logic [1:0]      wr_prec_eff,
  input logic [FLEN-1:0] wr_boxed,
  input logic [AW-1:0]   rd0_addr,
  input logic [1:0]      rd0_prec,
  input logic            rd0_raw,
  input logic [FLEN-1:0] rd0_src,
  input logic [FLEN-1:0] rd0_data
);
  assert_single_box_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_prec_eff == 2'b01) |-> (wr_boxed[FLEN-1:32] == '1));

  assert_half_box_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_prec_eff == 2'b00) |-> (wr_boxed[FLEN-1:16] == '1));

  assert_bad_box_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd0_raw && rd0_prec == 2'b01 && rd0_src[FLEN-1:32] != '1)
      |-> (rd0_data == FLEN'(64'h7FC0_0000)));

  assert_raw_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_raw |-> (rd0_data == rd0_src));

  assert_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd0_addr == wr_addr_eff) |-> (rd0_src == wr_boxed));

  assert_stored_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd0_addr == wr_addr_eff) |=>
      ((rd0_addr != $past(rd0_addr)) || wr_fire || (rd0_src == $past(wr_boxed))));

  assert_illegal_nowrite_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mv_illegal |-> !mv_wr);

  assert_move_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_wr && wr_en) |-> (wr_addr_eff == mv_freg));
endmodule

bind fp_boxreg_file fpr_checker #(.FLEN(FLEN), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_fire     (wr_fire),
  .mv_wr       (mv_wr),
  .mv_illegal  (mv_illegal),
  .mv_freg     (mv_freg),
  .wr_addr_eff (wr_addr_eff),
  .wr_prec_eff (wr_prec_eff),
  .wr_boxed    (wr_boxed),
  .rd0_addr    (rd0_addr),
  .rd0_prec    (rd0_prec),
  .rd0_raw     (rd0_raw),
  .rd0_src     (rd0_src),
  .rd0_data    (rd0_data)
);

// File: tb/fp_boxreg_file_tb.sv
`timescale 1ns/1ps
module fp_boxreg_file_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        wr_en, rd0_raw, rd1_raw, mv_valid, mv_to_float, mv_illegal;
  logic [4:0]  wr_addr, rd0_addr, rd1_addr, mv_freg;
  logic [1:0]  wr_prec, rd0_prec, rd1_prec, mv_prec;
  logic [63:0] wr_data, rd0_data, rd1_data, mv_xsrc, mv_xres;

  // Second instance with a 32-bit integer width, for illegal double moves.
  logic        n_mv_valid, n_mv_to_float, n_mv_illegal, n_rd0_raw;
  logic [1:0]  n_mv_prec;
  logic [4:0]  n_mv_freg, n_rd0_addr;
  logic [31:0] n_mv_xsrc, n_mv_xres;
  logic [63:0] n_rd0_data, n_rd1_data;

  int checks = 0;
  int fails  = 0;
  logic [63:0] model [32];

  fp_boxreg_file u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_prec(wr_prec), .wr_data(wr_data),
    .rd0_addr(rd0_addr), .rd0_prec(rd0_prec), .rd0_raw(rd0_raw), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_prec(rd1_prec), .rd1_raw(rd1_raw), .rd1_data(rd1_data),
    .mv_valid(mv_valid), .mv_to_float(mv_to_float), .mv_prec(mv_prec),
    .mv_freg(mv_freg), .mv_xsrc(mv_xsrc), .mv_xres(mv_xres), .mv_illegal(mv_illegal)
  );

  fp_boxreg_file #(.XLEN(32)) u_dut32 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(1'b0), .wr_addr(5'd0), .wr_prec(2'b10), .wr_data(64'h0),
    .rd0_addr(n_rd0_addr), .rd0_prec(2'b10), .rd0_raw(n_rd0_raw), .rd0_data(n_rd0_data),
    .rd1_addr(5'd0), .rd1_prec(2'b10), .rd1_raw(1'b1), .rd1_data(n_rd1_data),
    .mv_valid(n_mv_valid), .mv_to_float(n_mv_to_float), .mv_prec(n_mv_prec),
    .mv_freg(n_mv_freg), .mv_xsrc(n_mv_xsrc), .mv_xres(n_mv_xres), .mv_illegal(n_mv_illegal)
  );

  function automatic logic [63:0] b_box(input logic [1:0] p, input logic [63:0] d);
    if (p == 2'b00) return {48'hFFFF_FFFF_FFFF, d[15:0]};
    if (p == 2'b01) return {32'hFFFF_FFFF, d[31:0]};
    return d;
  endfunction

  function automatic logic [63:0] b_read(input logic [1:0] p, input logic r, input logic [63:0] v);
    if (r || p[1]) return v;
    if (p == 2'b00) return (v[63:16] == 48'hFFFF_FFFF_FFFF) ? {48'h0, v[15:0]} : 64'h7E00;
    return (v[63:32] == 32'hFFFF_FFFF) ? {32'h0, v[31:0]} : 64'h7FC0_0000;
  endfunction

  function automatic string b_tag(input logic [1:0] p, input logic r, input logic [63:0] v, input logic fw);
    if (fw) return "R6";
    if (r || p[1]) return "R4";
    if (p == 2'b00) return (v[63:16] == 48'hFFFF_FFFF_FFFF) ? "R2" : "R3";
    return (v[63:32] == 32'hFFFF_FFFF) ? "R2" : "R3";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_addr = 0; wr_prec = 0; wr_data = 0;
    rd0_addr = 0; rd0_prec = 2'b10; rd0_raw = 1; rd1_addr = 0; rd1_prec = 2'b10; rd1_raw = 1;
    mv_valid = 0; mv_to_float = 0; mv_prec = 2'b01; mv_freg = 0; mv_xsrc = 0;
  endtask

  // Inputs are set just after a falling edge; check combinational outputs, then clock.
  task automatic step();
    logic mlegal, mvwr, fire, f0, f1;
    logic [4:0]  ea;
    logic [63:0] eb, v0, v1, vm, xexp;
    string t;
    #1;
    mlegal = (mv_prec == 2'b01) || (mv_prec == 2'b10);
    mvwr = mv_valid && mlegal && mv_to_float;
    fire = mvwr || wr_en;
    ea = mvwr ? mv_freg : wr_addr;
    eb = mvwr ? ((mv_prec == 2'b01) ? {32'hFFFF_FFFF, mv_xsrc[31:0]} : mv_xsrc)
              : b_box(wr_prec, wr_data);
    f0 = fire && ea == rd0_addr;
    f1 = fire && ea == rd1_addr;
    v0 = f0 ? eb : model[rd0_addr];
    v1 = f1 ? eb : model[rd1_addr];
    vm = (fire && ea == mv_freg) ? eb : model[mv_freg];
    check(b_tag(rd0_prec, rd0_raw, v0, f0), rd0_data, b_read(rd0_prec, rd0_raw, v0));
    check(b_tag(rd1_prec, rd1_raw, v1, f1), rd1_data, b_read(rd1_prec, rd1_raw, v1));
    check("R10", {63'h0, mv_illegal}, {63'h0, mv_valid && !mlegal});
    if (mv_valid && mlegal && !mv_to_float)
      xexp = (mv_prec == 2'b01) ? {{32{vm[31]}}, vm[31:0]} : vm;
    else
      xexp = 64'h0;
    t = !(mv_valid && mlegal && !mv_to_float) ? "R10" : (mv_prec == 2'b01) ? "R7" : "R9";
    check(t, mv_xres, xexp);
    @(posedge clk);
    if (fire) model[ea] = eb;
    @(negedge clk);
  endtask

  initial begin
    #(1_500_000ns);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4217));
    for (int i = 0; i < 32; i++) model[i] = 64'h0;
    idle();
    n_mv_valid = 0; n_mv_to_float = 0; n_mv_prec = 2'b01; n_mv_freg = 0; n_mv_xsrc = 0;
    n_rd0_addr = 0; n_rd0_raw = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R5: reset state, raw and unboxed single.
    rd0_addr = 5'd7; rd0_raw = 1; rd1_addr = 5'd7; rd1_raw = 0; rd1_prec = 2'b01;
    #1;
    check("R5", rd0_data, 64'h0);
    check("R5", rd1_data, 64'h7FC0_0000);
    idle(); step();

    // R1: half write, raw readback next cycle; R2 half unbox.
    wr_en = 1; wr_addr = 3; wr_prec = 2'b00; wr_data = 64'h1234_5678_9ABC_DEF0;
    step(); idle();
    rd0_addr = 3; rd0_raw = 1; rd1_addr = 3; rd1_raw = 0; rd1_prec = 2'b00;
    #1;
    check("R1", rd0_data, 64'hFFFF_FFFF_FFFF_DEF0);
    check("R2", rd1_data, 64'h0000_0000_0000_DEF0);
    step();

    // R3: half read of a single-boxed value -> 0x7E00.
    idle(); wr_en = 1; wr_addr = 4; wr_prec = 2'b01; wr_data = 64'h0000_0000_3F80_0000;
    step(); idle();
    rd0_addr = 4; rd0_raw = 0; rd0_prec = 2'b00; rd1_addr = 4; rd1_raw = 0; rd1_prec = 2'b01;
    #1;
    check("R3", rd0_data, 64'h7E00);
    check("R2", rd1_data, 64'h3F80_0000);
    step();

    // R11: move beats wr_en; R8 single boxing through the move.
    idle(); wr_en = 1; wr_addr = 9; wr_prec = 2'b10; wr_data = 64'hAAAA_AAAA_AAAA_AAAA;
    mv_valid = 1; mv_to_float = 1; mv_prec = 2'b01; mv_freg = 10; mv_xsrc = 64'h5555_5555_C0DE_CAFE;
    step(); idle();
    rd0_addr = 9; rd1_addr = 10;
    #1;
    check("R11", rd0_data, 64'h0);
    check("R8", rd1_data, 64'hFFFF_FFFF_C0DE_CAFE);
    step();

    // R7: raw sign-extending move out of a double-written register.
    idle(); wr_en = 1; wr_addr = 12; wr_prec = 2'b10; wr_data = 64'h0123_4567_89AB_CDEF;
    step(); idle();
    mv_valid = 1; mv_to_float = 0; mv_prec = 2'b01; mv_freg = 12;
    #1;
    check("R7", mv_xres, 64'hFFFF_FFFF_89AB_CDEF);
    step();

    // R10: illegal codes and double moves at integer width 32.
    idle(); mv_valid = 1; mv_to_float = 1; mv_prec = 2'b11; mv_freg = 12; mv_xsrc = 64'h1;
    step(); idle(); rd0_addr = 12; #1;
    check("R10", rd0_data, 64'h0123_4567_89AB_CDEF);
    step();
    n_mv_valid = 1; n_mv_to_float = 1; n_mv_prec = 2'b10; n_mv_freg = 2; n_mv_xsrc = 32'hDEAD_BEEF;
    #1;
    check("R10", {63'h0, n_mv_illegal}, 64'h1);
    @(posedge clk); @(negedge clk);
    n_mv_valid = 0; n_rd0_addr = 2; #1;
    check("R10", n_rd0_data, 64'h0);
    n_mv_valid = 1; n_mv_to_float = 1; n_mv_prec = 2'b01; #1;
    check("R10", {63'h0, n_mv_illegal}, 64'h0);
    @(posedge clk); @(negedge clk);
    n_mv_valid = 1; n_mv_to_float = 0; n_mv_prec = 2'b01; n_mv_freg = 2; #1;
    check("R7", {32'h0, n_mv_xres}, 64'hDEAD_BEEF);
    n_mv_valid = 0;

    // R9: double move in and out; R12 independent ports.
    idle(); mv_valid = 1; mv_to_float = 1; mv_prec = 2'b10; mv_freg = 20; mv_xsrc = 64'h7FF0_0000_0000_0001;
    step(); idle();
    mv_valid = 1; mv_to_float = 0; mv_prec = 2'b10; mv_freg = 20;
    rd0_addr = 20; rd0_raw = 0; rd0_prec = 2'b01; rd1_addr = 3; rd1_raw = 0; rd1_prec = 2'b00;
    #1;
    check("R9", mv_xres, 64'h7FF0_0000_0000_0001);
    check("R12", rd0_data, 64'h7FC0_0000);
    check("R12", rd1_data, 64'hDEF0);
    step();

    // R6: directed forward of a single write to an unboxed read.
    idle(); wr_en = 1; wr_addr = 21; wr_prec = 2'b01; wr_data = 64'h4049_0FDB;
    rd0_addr = 21; rd0_raw = 0; rd0_prec = 2'b01;
    #1;
    check("R6", rd0_data, 64'h4049_0FDB);
    step();

    // Random mix over a small address pool.
    for (int n = 0; n < 4000; n++) begin
      logic [63:0] d;
      idle();
      case ($urandom_range(0, 2))
        0: d = {32'hFFFF_FFFF, $urandom()};
        1: d = {16'hFFFF, 16'($urandom()), $urandom()};
        default: d = {$urandom(), $urandom()};
      endcase
      wr_en = ($urandom_range(0, 2) != 0);
      wr_addr = 5'($urandom_range(0, 3));
      wr_prec = 2'($urandom_range(0, 3));
      wr_data = d;
      rd0_addr = 5'($urandom_range(0, 3)); rd0_prec = 2'($urandom_range(0, 3)); rd0_raw = ($urandom_range(0, 3) == 0);
      rd1_addr = 5'($urandom_range(0, 3)); rd1_prec = 2'($urandom_range(0, 3)); rd1_raw = ($urandom_range(0, 3) == 0);
      mv_valid = ($urandom_range(0, 2) == 0);
      mv_to_float = $urandom_range(0, 1) == 1;
      mv_prec = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(0, 3)) : 2'($urandom_range(1, 2));
      mv_freg = 5'($urandom_range(0, 3));
      mv_xsrc = {$urandom(), $urandom()};
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule